// File: doc/BRIEF.md
# Internal-Data Operand Address Resolver

This block sits between the instruction decoder and the internal data space of an 8-bit microcontroller core. The decoder hands it an operand specifier: an addressing-mode code, one operand byte and an optional second immediate byte. The block returns the physical 8-bit internal address that the operand names, a flag saying whether that address lives in the special-function-register (SFR) space or in internal RAM, and the bit index when the operand is a single bit. Immediate constants are not resolved to an address; they are passed through on a separate field.

Register operands are moved by the active register bank, which comes in on a plain control input. For a register-indirect operand the block reads the pointer register (R0 or R1 of the active bank) from internal RAM through its own read port. It then reports the pointer's contents as a RAM address, because indirect accesses never reach the SFRs. The same byte value can therefore name a RAM location in one mode and an SFR in another.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A result is held, unchanged, from the edge that raises `res_valid` until an edge where `res_ready` is high. `req_ready` is low while a result waits unconsumed and while a pointer read is in flight. It is therefore safe to present a new request in the same cycle as `res_ready`. The single-cycle `res_valid` pulse seen under a free-flowing consumer is the done strobe.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 0 (register): `res_addr` = bank*8 + req_sel[2:0], where bank is `bank_sel` in the accepting cycle. `res_sfr`=0. The result is valid after the first rising edge following acceptance.
- R2: Mode code 1 (direct), and the unused codes 6 and 7: `res_addr` = req_sel and `res_sfr` = req_sel[7], so 00H–7FH is RAM and 80H–FFH is SFR. Latency is one edge.
- R3: Mode code 2 (register-indirect): in the accepting cycle `ptr_rd_en`=1 and `ptr_rd_addr` = bank*8 + req_sel[0]. The byte on `ptr_rd_data` one cycle later becomes `res_addr` with `res_sfr`=0 for every value 00H–FFH. The result is valid after the second edge following acceptance.
- R4: Mode code 3 (bit) with req_sel[7]=0: `res_addr` = 20H + req_sel[6:3], `res_sfr`=0, `res_is_bit`=1, `res_bitpos` = req_sel[2:0].
- R5: Mode code 3 with req_sel[7]=1: `res_addr` = req_sel with bits 2:0 cleared, `res_sfr`=1, `res_is_bit`=1, `res_bitpos` = req_sel[2:0]. An SFR result always has `res_addr[7]`=1.
- R6: Mode code 4 gives `res_imm` = {8'h00, req_sel}. Mode code 5 gives `res_imm` = {req_hi, req_sel}. Both give `res_imm_valid`=1 and `res_addr`=0. Non-immediate modes give `res_imm_valid`=0 and `res_imm`=0, and non-bit modes give `res_is_bit`=0 and `res_bitpos`=0.
- R7: While `res_valid`=1 and `res_ready`=0, every result field stays stable, `req_ready`=0, and a change of `bank_sel` has no effect. A new request can be accepted on the same edge that consumes the old result.
- R8: In the cycle after a pointer read is issued, `req_ready`=0 and `res_valid`=0.
- R9: A synchronous reset clears `res_valid` on the next edge and returns the block to idle, with `req_ready`=1 and `ptr_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 2 | Active register bank |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 3 | Addressing-mode code |
| req_sel | input | 8 | Operand byte (register index, address, bit address or low immediate) |
| req_hi | input | 8 | High immediate byte for mode 5 |
| ptr_rd_en | output | 1 | Pointer register read strobe |
| ptr_rd_addr | output | 8 | RAM address of the pointer register |
| ptr_rd_data | input | 8 | Pointer contents, one cycle after the strobe |
| res_valid | output | 1 | Result present (done strobe) |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 8 | Resolved internal address |
| res_sfr | output | 1 | 1 = SFR space, 0 = internal RAM |
| res_is_bit | output | 1 | Operand is a single bit |
| res_bitpos | output | 3 | Bit index within the byte |
| res_imm_valid | output | 1 | Result is an immediate constant |
| res_imm | output | 16 | Immediate constant |

## Verification
Register, direct, bit and immediate results are due one rising edge after the accepting edge. Indirect results are due two edges after it, with the pointer strobe visible in the accepting cycle itself. The bench drives every request just after a falling edge and samples just after a falling edge. It checks the pointer strobe before the accepting edge, the empty middle cycle of an indirect access at the next falling edge, and each result at the falling edge where it is due. Under back-pressure the bench samples the held result at two successive falling edges, and then checks that the request presented alongside the consuming edge appears one edge later.

// File: rtl/opres_pkg.sv
package opres_pkg;

  localparam int DATA_ADDR_W = 8;
  localparam int IMM_W       = 16;
  localparam int BITPOS_W    = 3;

  typedef enum logic [2:0] {
    MODE_REG   = 3'd0,
    MODE_DIR   = 3'd1,
    MODE_IND   = 3'd2,
    MODE_BIT   = 3'd3,
    MODE_IMM8  = 3'd4,
    MODE_IMM16 = 3'd5
  } opnd_mode_e;

  typedef struct packed {
    logic [DATA_ADDR_W-1:0] addr;
    logic                   sfr;
    logic                   is_bit;
    logic [BITPOS_W-1:0]    pos;
    logic                   imm_valid;
    logic [IMM_W-1:0]       imm;
  } opnd_res_t;

endpackage

// File: rtl/opres_reg_locator.sv
module opres_reg_locator #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  // Each bank is 2**IDX_W bytes, banks are stacked from address zero.
  generate
    if (PAD_W > 0) begin : g_pad
      assign addr = {{PAD_W{1'b0}}, bank, idx};
    end else begin : g_nopad
      assign addr = {bank, idx};
    end
  endgenerate
endmodule

// File: rtl/opres_bit_locator.sv
module opres_bit_locator #(
  parameter logic [7:0] BIT_RAM_BASE = 8'h20
) (
  input  logic [7:0] bit_addr,
  output logic [7:0] byte_addr,
  output logic       in_sfr,
  output logic [2:0] pos
);
  logic [7:0] ram_byte;
  logic [7:0] sfr_byte;

  // Lower half: 128 bits packed into 16 RAM bytes from the base.
  assign ram_byte  = BIT_RAM_BASE + {4'b0000, bit_addr[6:3]};
  // Upper half: bit lives in the SFR whose address is a multiple of 8.
  assign sfr_byte  = {bit_addr[7:3], 3'b000};
  assign in_sfr    = bit_addr[7];
  assign byte_addr = in_sfr ? sfr_byte : ram_byte;
  assign pos       = bit_addr[2:0];
endmodule

// File: rtl/opres_ctrl.sv
module opres_ctrl
  import opres_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_is_ind,
  input  opnd_res_t  next_res,
  input  logic [7:0] ptr_rd_data,
  input  logic       res_ready,
  output logic       req_ready,
  output logic       ptr_issue,
  output logic       res_valid,
  output opnd_res_t  res
);
  typedef enum logic {ST_IDLE = 1'b0, ST_PTR = 1'b1} ctrl_state_e;

  ctrl_state_e state;
  logic        accept;

  assign req_ready = (state == ST_IDLE) && (!res_valid || res_ready);
  assign accept    = req_valid && req_ready;
  assign ptr_issue = accept && req_is_ind;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_is_ind) begin
              state     <= ST_PTR;
              res_valid <= 1'b0;
            end else begin
              res       <= next_res;
              res_valid <= 1'b1;
            end
          end else if (res_valid && res_ready) begin
            res_valid <= 1'b0;
          end
        end
        default: begin
          // Pointer byte arrives now; indirect targets are always RAM.
          res       <= '0;
          res.addr  <= ptr_rd_data;
          res_valid <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: reset empties the output and returns to idle
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!res_valid && state == ST_IDLE));

  // R7: a stalled result does not move
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res)));

  // R8: the cycle after a pointer read is a bubble
  a_r8_ptr_bubble: assert property (@(posedge clk) disable iff (rst)
    ptr_issue |=> (!req_ready && !res_valid));

  // R3: an indirect result appears two edges on and is never an SFR
  a_r3_ind_is_ram: assert property (@(posedge clk) disable iff (rst)
    ptr_issue |=> ##1 (res_valid && !res.sfr && !res.is_bit));

  // R5: SFR results lie in the upper half of the address space
  a_r5_sfr_upper: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res.sfr) |-> res.addr[7]);

  // R4: RAM bit results lie in the lower half
  a_r4_bit_ram_low: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res.is_bit && !res.sfr) |-> !res.addr[7]);

  // R6: immediates never carry an SFR select or a bit flag
  a_r6_imm_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res.imm_valid) |-> (!res.sfr && !res.is_bit));
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opres_pkg::*;
#(
  parameter int         BANK_W       = 2,
  parameter int         REG_IDX_W    = 3,
  parameter logic [7:0] BIT_RAM_BASE = 8'h20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bank_sel,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_mode,
  input  logic [7:0]  req_sel,
  input  logic [7:0]  req_hi,
  output logic        ptr_rd_en,
  output logic [7:0]  ptr_rd_addr,
  input  logic [7:0]  ptr_rd_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [7:0]  res_addr,
  output logic        res_sfr,
  output logic        res_is_bit,
  output logic [2:0]  res_bitpos,
  output logic        res_imm_valid,
  output logic [15:0] res_imm
);
  localparam int PTR_PAD_W = REG_IDX_W - 1;

  logic                 is_ind;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [7:0]           reg_addr;
  logic [7:0]           bit_byte;
  logic                 bit_sfr;
  logic [2:0]           bit_pos;
  opnd_res_t            next_res;
  opnd_res_t            res_q;

  assign is_ind  = (req_mode == MODE_IND);
  // Indirect mode only reaches the two pointer registers of the bank.
  assign reg_idx = is_ind ? {{PTR_PAD_W{1'b0}}, req_sel[0]}
                          : req_sel[REG_IDX_W-1:0];

  opres_reg_locator #(
    .ADDR_W (DATA_ADDR_W),
    .BANK_W (BANK_W),
    .IDX_W  (REG_IDX_W)
  ) u_reg_loc (
    .bank (bank_sel),
    .idx  (reg_idx),
    .addr (reg_addr)
  );

  opres_bit_locator #(
    .BIT_RAM_BASE (BIT_RAM_BASE)
  ) u_bit_loc (
    .bit_addr  (req_sel),
    .byte_addr (bit_byte),
    .in_sfr    (bit_sfr),
    .pos       (bit_pos)
  );

  always_comb begin
    next_res = '0;
    case (req_mode)
      MODE_REG: next_res.addr = reg_addr;
      MODE_IND: next_res      = '0;
      MODE_BIT: begin
        next_res.addr   = bit_byte;
        next_res.sfr    = bit_sfr;
        next_res.is_bit = 1'b1;
        next_res.pos    = bit_pos;
      end
      MODE_IMM8: begin
        next_res.imm_valid = 1'b1;
        next_res.imm       = {8'h00, req_sel};
      end
      MODE_IMM16: begin
        next_res.imm_valid = 1'b1;
        next_res.imm       = {req_hi, req_sel};
      end
      default: begin
        next_res.addr = req_sel;
        next_res.sfr  = req_sel[7];
      end
    endcase
  end

  opres_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_ind  (is_ind),
    .next_res    (next_res),
    .ptr_rd_data (ptr_rd_data),
    .res_ready   (res_ready),
    .req_ready   (req_ready),
    .ptr_issue   (ptr_rd_en),
    .res_valid   (res_valid),
    .res         (res_q)
  );

  assign ptr_rd_addr   = reg_addr;
  assign res_addr      = res_q.addr;
  assign res_sfr       = res_q.sfr;
  assign res_is_bit    = res_q.is_bit;
  assign res_bitpos    = res_q.pos;
  assign res_imm_valid = res_q.imm_valid;
  assign res_imm       = res_q.imm;

  // R3: the pointer read always targets R0 or R1 of a bank
  a_r3_ptr_in_bank: assert property (@(posedge clk) disable iff (rst)
    ptr_rd_en |-> (ptr_rd_addr[2:1] == 2'b00 && ptr_rd_addr[7:5] == 3'b000));
endmodule

// File: tb/test_opnd_resolver.sv
module test_opnd_resolver;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bank_sel;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_mode;
  logic [7:0]  req_sel;
  logic [7:0]  req_hi;
  logic        ptr_rd_en;
  logic [7:0]  ptr_rd_addr;
  logic [7:0]  ptr_rd_data;
  logic        res_valid;
  logic        res_ready;
  logic [7:0]  res_addr;
  logic        res_sfr;
  logic        res_is_bit;
  logic [2:0]  res_bitpos;
  logic        res_imm_valid;
  logic [15:0] res_imm;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  opnd_resolver i_opnd_resolver (
    .clk (clk), .rst (rst), .bank_sel (bank_sel),
    .req_valid (req_valid), .req_ready (req_ready), .req_mode (req_mode),
    .req_sel (req_sel), .req_hi (req_hi),
    .ptr_rd_en (ptr_rd_en), .ptr_rd_addr (ptr_rd_addr), .ptr_rd_data (ptr_rd_data),
    .res_valid (res_valid), .res_ready (res_ready), .res_addr (res_addr),
    .res_sfr (res_sfr), .res_is_bit (res_is_bit), .res_bitpos (res_bitpos),
    .res_imm_valid (res_imm_valid), .res_imm (res_imm)
  );

  function automatic logic [7:0] ram_val(input logic [7:0] a);
    return a ^ 8'hC3;
  endfunction

  // Synchronous-read RAM model for the pointer port
  always_ff @(posedge clk) begin
    if (ptr_rd_en) ptr_rd_data <= ram_val(ptr_rd_addr);
  end

  // mode, sel, hi, bank | addr, sfr, is_bit, pos, imm_valid, imm
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 8'h05, 8'h00, 2'd2, 8'h15, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd0, 8'h07, 8'h00, 2'd3, 8'h1F, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd0, 8'h00, 8'h00, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd1, 8'h7F, 8'h00, 2'd1, 8'h7F, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd1, 8'h80, 8'h00, 2'd1, 8'h80, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd7, 8'hE0, 8'h00, 2'd0, 8'hE0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000},
    {3'd3, 8'h00, 8'h00, 2'd3, 8'h20, 1'b0, 1'b1, 3'd0, 1'b0, 16'h0000},
    {3'd3, 8'h7F, 8'h00, 2'd0, 8'h2F, 1'b0, 1'b1, 3'd7, 1'b0, 16'h0000},
    {3'd3, 8'h3A, 8'h00, 2'd1, 8'h27, 1'b0, 1'b1, 3'd2, 1'b0, 16'h0000},
    {3'd3, 8'h80, 8'h00, 2'd2, 8'h80, 1'b1, 1'b1, 3'd0, 1'b0, 16'h0000},
    {3'd3, 8'hD5, 8'h00, 2'd0, 8'hD0, 1'b1, 1'b1, 3'd5, 1'b0, 16'h0000},
    {3'd4, 8'h9C, 8'h12, 2'd1, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 16'h009C},
    {3'd5, 8'h34, 8'h12, 2'd3, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 16'h1234}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] res_bus();
    return {res_addr, res_sfr, res_is_bit, res_bitpos, res_imm_valid, res_imm};
  endfunction

  task automatic drive(input logic [2:0] m, input logic [7:0] s,
                       input logic [7:0] h, input logic [1:0] b);
    req_mode  = m;
    req_sel   = s;
    req_hi    = h;
    bank_sel  = b;
    req_valid = 1'b1;
  endtask

  task automatic check_ind(input logic sel0, input logic [1:0] b);
    logic [7:0] pa;
    pa = {3'b000, b, 2'b00, sel0};
    @(negedge clk);
    drive(3'd2, {7'h55, sel0}, 8'h00, b);
    #1;
    chk(ptr_rd_en == 1'b1, "R3", "ptr_rd_en in accept cycle", 64'(ptr_rd_en), 64'd1);
    chk(ptr_rd_addr == pa, "R3", "ptr_rd_addr", 64'(ptr_rd_addr), 64'(pa));
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b0, "R8", "res_valid in bubble", 64'(res_valid), 64'd0);
    chk(req_ready == 1'b0, "R8", "req_ready in bubble", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R3", "res_valid after two edges", 64'(res_valid), 64'd1);
    chk(res_bus() == {ram_val(pa), 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000}, "R3",
        "indirect result", 64'(res_bus()), 64'({ram_val(pa), 22'h0}));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; res_ready = 1'b1;
    req_mode = 3'd0; req_sel = 8'h00; req_hi = 8'h00; bank_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R9", "res_valid in reset", 64'(res_valid), 64'd0);
    chk(req_ready == 1'b1, "R9", "req_ready in reset", 64'(req_ready), 64'd1);
    chk(ptr_rd_en == 1'b0, "R9", "ptr_rd_en in reset", 64'(ptr_rd_en), 64'd0);
    rst = 1'b0;

    // Table walk: R1, R2, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      string tag;
      v = VEC[i];
      case (v[50:48])
        3'd0: tag = "R1";
        3'd3: tag = v[47] ? "R5" : "R4";
        3'd4, 3'd5: tag = "R6";
        default: tag = "R2";
      endcase
      @(negedge clk);
      drive(v[50:48], v[47:40], v[39:32], v[31:30]);
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid == 1'b1, tag, "res_valid one edge after accept", 64'(res_valid), 64'd1);
      chk(res_bus() == v[29:0], tag, "result fields", 64'(res_bus()), 64'(v[29:0]));
    end

    // R3 / R8: indirect through R0 and R1 of different banks
    check_ind(1'b0, 2'd1);
    check_ind(1'b1, 2'd3);
    check_ind(1'b1, 2'd0);

    // R7: back-pressure holds the result, ignores a bank change
    @(negedge clk);
    res_ready = 1'b0;
    drive(3'd0, 8'h02, 8'h00, 2'd1);
    @(negedge clk);
    chk(res_valid && res_addr == 8'h0A, "R7", "stalled result", 64'(res_addr), 64'h0A);
    chk(req_ready == 1'b0, "R7", "req_ready while stalled", 64'(req_ready), 64'd0);
    drive(3'd1, 8'h11, 8'h00, 2'd3);
    @(negedge clk);
    chk(res_valid && res_addr == 8'h0A && !res_sfr, "R7", "result held after bank change",
        64'(res_addr), 64'h0A);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid && res_addr == 8'h11, "R7", "request taken with consuming edge",
        64'(res_addr), 64'h11);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", "result drained", 64'(res_valid), 64'd0);

    // R9: reset mid-stream while a result is stalled
    res_ready = 1'b0;
    drive(3'd1, 8'hA0, 8'h00, 2'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", "res_valid after reset", 64'(res_valid), 64'd0);
    chk(req_ready == 1'b1, "R9", "req_ready after reset", 64'(req_ready), 64'd1);
    rst = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule